// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Line-Break Detection

This block recovers characters from an asynchronous serial line. A two-flop synchroniser brings the line into the clock domain. Sampling then advances only on an oversampling enable, which pulses sixteen times per bit period. The character format comes in as inputs and is held stable while a character is in flight: 5 to 8 data bits, an optional parity bit of one of four kinds, and one stop bit. Each completed character leaves the block as a one-cycle valid strobe. The strobe carries the data byte and three flags that belong to that character: framing error, parity error and line break.

A stop bit that reads low is reported as a framing error. The receiver then treats that low bit as the start bit of the next character and goes on assembling at once, with no new falling edge needed. A line held low from the start bit through the stop bit is a break, not a framing error. The block reports it once, as a zero byte with the break flag set. It then ignores the line until the line returns high. The baud-rate divider, the receive FIFO and any register access sit outside the block.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, rx_valid, rx_ferr, rx_perr and rx_brk are low, and no character is reported while the line stays high.
- R2: Data bits arrive least significant bit first. data_bits_sel selects the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of rx_data above the selected count read 0.
- R3: When par_en is 1, one parity bit follows the data. par_mode sets its expected value: 0 odd (data plus parity hold an odd number of ones), 1 even, 2 constant 1, 3 constant 0. rx_perr is set when the received parity bit differs from the expected value. When par_en is 0, no parity bit is taken and rx_perr is 0.
- R4: The start bit is checked at its middle (the 8th oversampling tick after the falling edge is seen). A low pulse that has ended by then produces no character.
- R5: If the stop bit samples low and the start, data and parity bits were not all low, the character is reported with rx_ferr = 1. That low stop bit is used as the start bit of a following character, which is assembled without a new falling edge.
- R6: If the start, data, parity and stop bits all sample low, exactly one record is reported: rx_data = 0, rx_brk = 1, rx_ferr = 1, rx_perr = 0.
- R7: After a break, no further character is reported while the line stays low. After the line returns high, the next frame is received normally.
- R8: rx_valid is high for exactly one clock per character. rx_ferr, rx_perr and rx_brk are 0 whenever rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_line | input | 1 | Serial input, idle high |
| data_bits_sel | input | 2 | Data bit count select (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | Parity kind: 0 odd, 1 even, 2 constant 1, 3 constant 0 |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| rx_data | output | 8 | Received data, unused upper bits zero |
| rx_ferr | output | 1 | Framing error for this character |
| rx_perr | output | 1 | Parity error for this character |
| rx_brk | output | 1 | This record is a line break |

## Verification
The assertions check on every cycle the shape of what leaves the block. The valid strobe lasts one clock. The flags are quiet between strobes. A break record carries a zero byte with the framing flag set and no parity flag. Data bits above the selected width are zero, and no parity error appears while parity is off. The bench scenarios cover the behaviour that depends on the line's history. These are the LSB-first assembly and parity verdict under random formats, glitch rejection at mid-start-bit, resynchronisation on a low stop bit into a character with no start edge, and the single report of a break followed by silence until the line goes high.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OSR      = 16;
  localparam int MAX_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } rx_state_e;

  typedef enum logic [1:0] {
    PM_ODD = 2'd0, PM_EVEN = 2'd1, PM_ONE = 2'd2, PM_ZERO = 2'd3
  } par_mode_e;

  function automatic logic expected_parity(input logic [MAX_BITS-1:0] d,
                                           input par_mode_e m);
    logic ones;
    ones = ^d;
    case (m)
      PM_ODD:  return ~ones;
      PM_EVEN: return ones;
      PM_ONE:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
  import uart_rx_pkg::*;
(
  input  logic [MAX_BITS-1:0] data,
  input  logic [1:0]          mode,
  input  logic                par_bit,
  output logic                mismatch
);
  assign mismatch = (par_bit != expected_parity(data, par_mode_e'(mode)));
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = OSR,
  parameter int NBITS      = MAX_BITS,
  localparam int CW        = $clog2(OVERSAMPLE),
  localparam int IW        = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  input  logic [1:0]       bits_sel,
  input  logic             par_en,
  input  logic             par_bad,
  output logic [NBITS-1:0] shift_q,
  output logic             par_bit_q,
  output logic             valid_q,
  output logic [NBITS-1:0] data_q,
  output logic             ferr_q,
  output logic             perr_q,
  output logic             brk_q
);
  localparam logic [CW-1:0] MID_LAST = CW'(OVERSAMPLE/2 - 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVERSAMPLE - 1);

  rx_state_e        st_q, st_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [IW-1:0]    idx_q, idx_n;
  logic [NBITS-1:0] shift_n, data_n;
  logic             zero_q, zero_n, par_bit_n;
  logic             valid_n, ferr_n, perr_n, brk_n;
  logic [IW-1:0]    last_idx;
  logic             sample;

  assign last_idx = IW'(bits_sel) + IW'(4);
  assign sample   = tick && (cnt_q == BIT_LAST);

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    idx_n     = idx_q;
    shift_n   = shift_q;
    zero_n    = zero_q;
    par_bit_n = par_bit_q;
    valid_n   = 1'b0;
    data_n    = data_q;
    ferr_n    = 1'b0;
    perr_n    = 1'b0;
    brk_n     = 1'b0;
    if (tick && st_q != ST_IDLE && st_q != ST_BRK) cnt_n = cnt_q + 1'b1;
    case (st_q)
      ST_IDLE: if (tick && !rx) begin
        st_n  = ST_START;
        cnt_n = '0;
      end
      ST_START: if (tick && cnt_q == MID_LAST) begin
        cnt_n   = '0;
        idx_n   = '0;
        shift_n = '0;
        zero_n  = 1'b1;
        st_n    = rx ? ST_IDLE : ST_DATA;
      end
      ST_DATA: if (sample) begin
        shift_n[idx_q] = rx;
        zero_n         = zero_q & ~rx;
        if (idx_q == last_idx) st_n = par_en ? ST_PAR : ST_STOP;
        else                   idx_n = idx_q + 1'b1;
      end
      ST_PAR: if (sample) begin
        par_bit_n = rx;
        zero_n    = zero_q & ~rx;
        st_n      = ST_STOP;
      end
      ST_STOP: if (sample) begin
        valid_n = 1'b1;
        if (rx) begin
          data_n = shift_q;
          perr_n = par_en & par_bad;
          st_n   = ST_IDLE;
        end else if (zero_q) begin
          data_n = '0;
          ferr_n = 1'b1;
          brk_n  = 1'b1;
          st_n   = ST_BRK;
        end else begin
          data_n  = shift_q;
          ferr_n  = 1'b1;
          perr_n  = par_en & par_bad;
          st_n    = ST_DATA;
          idx_n   = '0;
          shift_n = '0;
          zero_n  = 1'b1;
        end
      end
      ST_BRK: if (tick && rx) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      zero_q    <= 1'b0;
      par_bit_q <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= '0;
      ferr_q    <= 1'b0;
      perr_q    <= 1'b0;
      brk_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      idx_q     <= idx_n;
      shift_q   <= shift_n;
      zero_q    <= zero_n;
      par_bit_q <= par_bit_n;
      valid_q   <= valid_n;
      data_q    <= data_n;
      ferr_q    <= ferr_n;
      perr_q    <= perr_n;
      brk_q     <= brk_n;
    end
  end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rx_line,
  input  logic [1:0]          data_bits_sel,
  input  logic                par_en,
  input  logic [1:0]          par_mode,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_ferr,
  output logic                rx_perr,
  output logic                rx_brk
);
  logic                rx_s;
  logic [MAX_BITS-1:0] shift_w;
  logic                par_bit_w, par_bad_w;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  uart_rx_parity u_par (
    .data(shift_w), .mode(par_mode), .par_bit(par_bit_w), .mismatch(par_bad_w)
  );

  uart_rx_fsm #(.OVERSAMPLE(OSR), .NBITS(MAX_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
    .bits_sel(data_bits_sel), .par_en(par_en), .par_bad(par_bad_w),
    .shift_q(shift_w), .par_bit_q(par_bit_w),
    .valid_q(rx_valid), .data_q(rx_data),
    .ferr_q(rx_ferr), .perr_q(rx_perr), .brk_q(rx_brk)
  );
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] data_bits_sel,
  input logic       par_en,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_ferr,
  input logic       rx_perr,
  input logic       rx_brk
);
  logic [7:0] width_mask;
  assign width_mask = 8'hFF >> (2'd3 - data_bits_sel);

  // R8
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(rx_ferr || rx_perr || rx_brk));

  // R6
  break_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_data == 8'h00 && rx_ferr && !rx_perr));

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data & ~width_mask) == 8'h00));

  // R3
  no_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en) |-> !rx_perr);
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_bits_sel(data_bits_sel), .par_en(par_en),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
  .rx_perr(rx_perr), .rx_brk(rx_brk)
);

// File: tb/test_uart_rx_brk.sv
module test_uart_rx_brk;
  localparam int TDIV    = 3;
  localparam int BIT_CLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] data_bits_sel = 2'd3;
  logic       par_en = 1'b0;
  logic [1:0] par_mode = 2'd0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ferr, rx_perr, rx_brk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [10:0] recq[$];

  always #5 clk = ~clk;

  uart_rx_brk i_uart_rx_brk (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .data_bits_sel(data_bits_sel), .par_en(par_en), .par_mode(par_mode),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .rx_perr(rx_perr), .rx_brk(rx_brk)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      os_tick <= (c == 0);
      c = (c == TDIV - 1) ? 0 : c + 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rx_valid) recq.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
  end

  function automatic logic exp_par(input logic [7:0] d, input int nb,
                                   input logic [1:0] m);
    logic p;
    p = ^(d & (8'hFF >> (8 - nb)));
    case (m)
      2'd0: return ~p;
      2'd1: return p;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive_bit(input logic v);
    rx_line <= v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_body(input logic [7:0] d, input logic flip,
                           input logic stopv);
    int nb;
    nb = data_bits_sel + 5;
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (par_en) drive_bit(exp_par(d, nb, par_mode) ^ flip);
    drive_bit(stopv);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip);
    drive_bit(1'b0);
    send_body(d, flip, 1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic check_rec(input string req, input logic [10:0] exp);
    logic [10:0] got;
    checks++;
    if (recq.size() == 0) begin
      failures++;
      $display("FAIL %s: no record, expected %h", req, exp);
    end else begin
      got = recq.pop_front();
      if (got !== exp) begin
        failures++;
        $display("FAIL %s: record %h, expected %h", req, got, exp);
      end
    end
  endtask

  task automatic check_none(input string req);
    checks++;
    if (recq.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d extra records, expected 0 (first %h)",
               req, recq.size(), recq[0]);
      recq.delete();
    end
  endtask

  function automatic logic [10:0] mkrec(input logic b, input logic f,
                                        input logic p, input logic [7:0] d,
                                        input int nb);
    return {b, f, p, d & (8'hFF >> (8 - nb))};
  endfunction

  initial begin
    repeat (20) @(negedge clk);
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    checks++;
    if (rx_valid !== 1'b0 || rx_ferr !== 1'b0 || rx_perr !== 1'b0 || rx_brk !== 1'b0) begin
      failures++;
      $display("FAIL R1: outputs %b%b%b%b, expected 0000", rx_valid, rx_ferr, rx_perr, rx_brk);
    end
    rst_n <= 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    check_none("R1 idle line");

    // R2 directed widths
    data_bits_sel <= 2'd3; par_en <= 1'b0;
    send_frame(8'hA5, 1'b0);
    check_rec("R2 8-bit", mkrec(0, 0, 0, 8'hA5, 8));
    data_bits_sel <= 2'd0;
    send_frame(8'hFF, 1'b0);
    check_rec("R2 5-bit", mkrec(0, 0, 0, 8'hFF, 5));

    // R3 each parity kind, good and bad
    data_bits_sel <= 2'd2; par_en <= 1'b1;
    for (int m = 0; m < 4; m++) begin
      par_mode <= 2'(m);
      send_frame(8'h5B, 1'b0);
      check_rec("R3 good parity", mkrec(0, 0, 0, 8'h5B, 7));
      send_frame(8'h5B, 1'b1);
      check_rec("R3 bad parity", mkrec(0, 0, 1, 8'h5B, 7));
    end

    // R4 short glitch
    rx_line <= 1'b0;
    repeat (12) @(negedge clk);
    rx_line <= 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    check_none("R4 glitch");

    // R5 low stop bit, then a character with no start edge
    data_bits_sel <= 2'd3; par_en <= 1'b0;
    drive_bit(1'b0);
    send_body(8'hA5, 1'b0, 1'b0);
    send_body(8'h3C, 1'b0, 1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check_rec("R5 framing record", mkrec(0, 1, 0, 8'hA5, 8));
    check_rec("R5 resync record", mkrec(0, 0, 0, 8'h3C, 8));
    check_none("R5 nothing more");

    // R6 / R7 break with parity that would expect a 1
    par_en <= 1'b1; par_mode <= 2'd2;
    rx_line <= 1'b0;
    repeat (16 * BIT_CLK) @(negedge clk);
    check_rec("R6 break record", 11'b110_0000_0000);
    check_none("R7 silent while low");
    rx_line <= 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    par_mode <= 2'd1;
    send_frame(8'hC3, 1'b0);
    check_rec("R7 after break", mkrec(0, 0, 0, 8'hC3, 8));

    // R2 R3 random formats
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d;
      logic flip;
      int nb;
      d = 8'($urandom);
      data_bits_sel <= 2'($urandom);
      par_en <= 1'($urandom);
      par_mode <= 2'($urandom);
      flip = ($urandom % 4) == 0;
      @(negedge clk);
      nb = data_bits_sel + 5;
      send_frame(d, flip);
      check_rec("R2 R3 random", mkrec(0, 0, flip & par_en, d, nb));
    end
    check_none("R8 one record per frame");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule